// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address for a machine with 8 KB pages. A translation request carries the virtual address, the kind of access (read, write or instruction fetch), a two-bit privilege index and a physical-mode flag. The block answers with a physical address, a three-bit permission set (bit 0 read, bit 1 write, bit 2 execute) and a three-bit fault code.

Three kinds of request finish without touching memory. A physical-mode request passes straight through. An address whose upper bits are badly extended is refused. A kernel access inside the superpage window is relocated directly. Every other request walks a three-level table held in memory. Each level costs one 64-bit read, issued on a request/valid port. The walker handles one request at a time. It accepts a new request only while `reqReady` is high, and it ignores `reqValid` while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: With `reqPhys` high, `physAddr` equals the virtual address, `prot` is 3'b111, `fault` is 0 (success), no memory read is issued, and `done` rises on the first cycle after the request is accepted.
- R2: Bits 63:43 of the virtual address must all be equal. If they are not, the result is `fault` 1 (access violation) with `prot` 0 and `physAddr` 0, and no read is issued. Bit 42 alone takes no part in this check.
- R3: An address with bit 63 set and bits 42:41 equal to 2'b10 lies in the superpage window, and no read is issued. For privilege index 0 (kernel) the result has `prot` 3'b111 and `fault` 0. Its `physAddr` is bits 39:0 of the address, with address bit 40 moved to bit 43 and bits 42:40 cleared. Any other privilege index gives `fault` 1.
- R4: A walk reads level 1, then level 2, then level 3. The level-1 index is VA[42:33], the level-2 index is VA[32:23] and the level-3 index is VA[22:13]. Each read address is the current table base plus the index times 8. The first base is `ptBase`. The next base is entry bits 63:32 shifted left by 13. While a read waits for `memValid`, `memAddr` holds steady.
- R5: An entry at any level with bit 0 (valid) clear ends the walk with `fault` 2 (not valid), `prot` 0 and `physAddr` 0. No further read is issued.
- R6: A valid level-1 or level-2 entry with bit 8 (kernel read enable) clear ends the walk with `fault` 1.
- R7: At the leaf, with privilege index p, read and execute are granted by entry bit 8+p and write by entry bit 12+p. Access codes are 0 read, 1 write, 2 fetch, and 3 acts as read. If the permission the access needs is missing, the result is `fault` 1 with `prot` 0 and `physAddr` 0.
- R8: Leaf bits 1, 2 and 3 withdraw read, write and execute. If the access then lacks its permission, the fault is 5 for a fetch, 4 for a write and 3 for a read. The reduced `prot` and the physical address are still reported.
- R9: A successful walk returns `physAddr` equal to leaf bits 63:32 shifted left by 13, ORed with VA[12:0].
- R10: `done` is high for exactly one cycle per accepted request, and the results are valid in that cycle. `reqReady` is low from acceptance until after `done`. A request presented while busy is ignored.
- R11: After reset, `reqReady` is 1, `done` and `memReq` are 0, and `physAddr`, `prot` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqVa | input | 64 | Virtual address |
| reqAccess | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| reqPriv | input | 2 | Privilege index, 0 is kernel |
| reqPhys | input | 1 | Physical-mode bypass |
| ptBase | input | 64 | Physical base of the level-1 table |
| memReq | output | 1 | Table entry read outstanding |
| memAddr | output | 64 | Entry address |
| memValid | input | 1 | Read data valid, completes the read |
| memData | input | 64 | Table entry |
| done | output | 1 | One-cycle completion pulse |
| physAddr | output | 64 | Translated physical address |
| prot | output | 3 | Granted permissions: bit 0 read, bit 1 write, bit 2 execute |
| fault | output | 3 | 0 ok, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |

## Verification
The bench targets the sign check at its exact boundary. An address with only bit 42 set must still walk. A negative address with bits 42:41 equal to 2'b11 must walk rather than take the superpage path. A check one bit too wide or too narrow would fault or relocate those addresses. Superpage relocation is tested with bit 40 both set and clear, so a missing bit move shows up as a wrong physical address.

At the leaf, a wrong privilege shift would grant user or executive access from kernel bits. Swapping the order of the fault-on checks would return fault 3 where fault 4 or 5 belongs. An early fault that did not stop the walk shows up as extra memory reads, which the bench counts for every request. A busy walker that accepted a second request would produce a second `done` or a wrong result.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } faultE;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accessE;

  // entry bit positions; fault-on bits line up with prot after a shift by one
  localparam int EntValidBit = 0;
  localparam int EntFoLsb    = 1;
  localparam int EntReLsb    = 8;
  localparam int EntWeLsb    = 12;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;
    logic takeFast;
    logic stepLevel;
    logic takeWalk;
  } ctlStrobeT;

  function automatic logic [2:0] needOf(input accessE acc);
    case (acc)
      ACC_WRITE: return 3'b010;
      ACC_FETCH: return 3'b100;
      default:   return 3'b001;
    endcase
  endfunction

  function automatic faultE foFaultOf(input accessE acc);
    case (acc)
      ACC_FETCH: return FLT_FOE;
      ACC_WRITE: return FLT_FOW;
      default:   return FLT_FOR;
    endcase
  endfunction

endpackage

// File: rtl/pt_walker_ctl.sv
module pt_walker_ctl
  import pt_walker_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             fastDone,
  input  logic             memValid,
  input  logic             pteStop,
  output ctlStrobeT        strobe,
  output logic [LVL_W-1:0] level,
  output logic             memReq,
  output logic             reqReady,
  output logic             done
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FINISH} stateE;

  stateE            stQ, stD;
  logic [LVL_W-1:0] lvlQ, lvlD;

  always_comb begin
    stD    = stQ;
    lvlD   = lvlQ;
    strobe = '0;
    case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          lvlD = '0;
          if (fastDone) begin
            strobe.takeFast = 1'b1;
            stD = ST_FINISH;
          end else begin
            stD = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (memValid) begin
          if (pteStop || (lvlQ == LVL_W'(LEVELS - 1))) begin
            strobe.takeWalk = 1'b1;
            stD = ST_FINISH;
          end else begin
            strobe.stepLevel = 1'b1;
            lvlD = lvlQ + 1'b1;
          end
        end
      end
      ST_FINISH: stD = ST_IDLE;
      default:   stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ  <= ST_IDLE;
      lvlQ <= '0;
    end else begin
      stQ  <= stD;
      lvlQ <= lvlD;
    end
  end

  assign level    = lvlQ;
  assign memReq   = (stQ == ST_FETCH);
  assign reqReady = (stQ == ST_IDLE);
  assign done     = (stQ == ST_FINISH);

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 10,
  parameter int LEVELS     = 3,
  parameter int PTE_W      = 64,
  parameter int FRAME_LSB  = 32,
  parameter int LVL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobeT        strobe,
  input  logic [LVL_W-1:0] level,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqAccess,
  input  logic [1:0]       reqPriv,
  input  logic             reqPhys,
  input  logic [VA_W-1:0]  ptBase,
  input  logic [PTE_W-1:0] memData,
  output logic             fastDone,
  output logic             pteStop,
  output logic [VA_W-1:0]  memAddr,
  output logic [VA_W-1:0]  physAddr,
  output logic [2:0]       prot,
  output logic [2:0]       fault
);

  localparam int IMPL_W  = PAGE_SHIFT + LEVELS * IDX_W;
  localparam int SP_SRC  = IMPL_W - 3;
  localparam int SP_DST  = IMPL_W;
  localparam int FRAME_W = PTE_W - FRAME_LSB;

  logic [VA_W-1:0] vaQ;
  accessE          accQ;
  logic [1:0]      privQ;
  logic [VA_W-1:0] baseQ;
  logic [VA_W-1:0] physQ;
  logic [2:0]      protQ;
  faultE           faultQ;

  // ---------------- request classification (no memory needed) ----------------
  logic [VA_W-IMPL_W-1:0] upperBits;
  logic                   signOk, inWindow;
  logic [VA_W-1:0]        spPhys, fastPhys;
  logic [2:0]             fastProt;
  faultE                  fastFault;

  assign upperBits = reqVa[VA_W-1:IMPL_W];
  assign signOk    = (&upperBits) | ~(|upperBits);
  assign inWindow  = reqVa[VA_W-1] && (reqVa[IMPL_W-1 -: 2] == 2'b10);
  assign spPhys    = {{(VA_W-SP_DST-1){1'b0}}, reqVa[SP_SRC],
                      {(SP_DST-SP_SRC){1'b0}}, reqVa[SP_SRC-1:0]};

  always_comb begin
    fastDone  = 1'b1;
    fastFault = FLT_NONE;
    fastProt  = 3'b111;
    fastPhys  = reqVa;
    if (reqPhys) begin
      fastPhys = reqVa;
    end else if (!signOk) begin
      fastFault = FLT_ACV;
      fastProt  = 3'b000;
      fastPhys  = '0;
    end else if (inWindow) begin
      if (reqPriv == 2'd0) begin
        fastPhys = spPhys;
      end else begin
        fastFault = FLT_ACV;
        fastProt  = 3'b000;
        fastPhys  = '0;
      end
    end else begin
      fastDone  = 1'b0;
      fastProt  = 3'b000;
      fastPhys  = '0;
    end
  end

  // ---------------- per-level index extraction ----------------
  logic [IDX_W-1:0] lvlIdx [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign lvlIdx[g] = vaQ[PAGE_SHIFT + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign memAddr = baseQ + {{(VA_W-IDX_W-3){1'b0}}, lvlIdx[level], 3'b000};

  // ---------------- entry evaluation ----------------
  logic            isLeaf, entValid, readEn, writeEn;
  logic [2:0]      permRaw, permCut, needBits, foMask;
  logic [VA_W-1:0] framePhys, walkPhys;
  logic [2:0]      walkProt;
  faultE           walkFault;

  assign isLeaf    = (level == LVL_W'(LEVELS - 1));
  assign entValid  = memData[EntValidBit];
  assign readEn    = memData[EntReLsb + int'(privQ)];
  assign writeEn   = memData[EntWeLsb + int'(privQ)];
  assign permRaw   = {readEn, writeEn, readEn};
  assign needBits  = needOf(accQ);
  assign foMask    = memData[EntFoLsb +: 3];
  assign permCut   = permRaw & ~foMask;
  assign framePhys = {{(VA_W-FRAME_W-PAGE_SHIFT){1'b0}},
                      memData[PTE_W-1:FRAME_LSB], {PAGE_SHIFT{1'b0}}};

  always_comb begin
    pteStop   = 1'b1;
    walkFault = FLT_NONE;
    walkProt  = 3'b000;
    walkPhys  = '0;
    if (!entValid) begin
      walkFault = FLT_TNV;
    end else if (!isLeaf) begin
      if (!memData[EntReLsb]) walkFault = FLT_ACV;
      else                    pteStop   = 1'b0;
    end else if ((permRaw & needBits) == 3'b000) begin
      walkFault = FLT_ACV;
    end else begin
      walkProt = permCut;
      walkPhys = framePhys | {{(VA_W-PAGE_SHIFT){1'b0}}, vaQ[PAGE_SHIFT-1:0]};
      if ((permCut & needBits) == 3'b000) walkFault = foFaultOf(accQ);
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaQ    <= '0;
      accQ   <= ACC_READ;
      privQ  <= '0;
      baseQ  <= '0;
      physQ  <= '0;
      protQ  <= '0;
      faultQ <= FLT_NONE;
    end else begin
      if (strobe.loadReq) begin
        vaQ   <= reqVa;
        accQ  <= accessE'(reqAccess);
        privQ <= reqPriv;
        baseQ <= ptBase;
      end
      if (strobe.stepLevel) baseQ <= framePhys;
      if (strobe.takeFast) begin
        physQ  <= fastPhys;
        protQ  <= fastProt;
        faultQ <= fastFault;
      end else if (strobe.takeWalk) begin
        physQ  <= walkPhys;
        protQ  <= walkProt;
        faultQ <= walkFault;
      end
    end
  end

  assign physAddr = physQ;
  assign prot     = protQ;
  assign fault    = faultQ;

  logic unusedBits;
  assign unusedBits = ^{vaQ[VA_W-1:IMPL_W], memData[EntReLsb-1:EntFoLsb+3],
                        memData[FRAME_LSB-1:EntWeLsb+4]};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 10,
  parameter int LEVELS     = 3,
  parameter int PTE_W      = 64,
  parameter int FRAME_LSB  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVa,
  input  logic [1:0]      reqAccess,
  input  logic [1:0]      reqPriv,
  input  logic            reqPhys,
  input  logic [VA_W-1:0] ptBase,
  output logic            memReq,
  output logic [VA_W-1:0] memAddr,
  input  logic            memValid,
  input  logic [PTE_W-1:0] memData,
  output logic            done,
  output logic [VA_W-1:0] physAddr,
  output logic [2:0]      prot,
  output logic [2:0]      fault
);

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  ctlStrobeT        strobe;
  logic [LVL_W-1:0] level;
  logic             fastDone, pteStop;

  pt_walker_ctl #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .fastDone (fastDone),
    .memValid (memValid),
    .pteStop  (pteStop),
    .strobe   (strobe),
    .level    (level),
    .memReq   (memReq),
    .reqReady (reqReady),
    .done     (done)
  );

  pt_walker_dp #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W), .LEVELS(LEVELS),
    .PTE_W(PTE_W), .FRAME_LSB(FRAME_LSB), .LVL_W(LVL_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .level     (level),
    .reqVa     (reqVa),
    .reqAccess (reqAccess),
    .reqPriv   (reqPriv),
    .reqPhys   (reqPhys),
    .ptBase    (ptBase),
    .memData   (memData),
    .fastDone  (fastDone),
    .pteStop   (pteStop),
    .memAddr   (memAddr),
    .physAddr  (physAddr),
    .prot      (prot),
    .fault     (fault)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reqReady,
  input logic            memReq,
  input logic            memValid,
  input logic [VA_W-1:0] memAddr,
  input logic            done,
  input logic [VA_W-1:0] physAddr,
  input logic [2:0]      prot,
  input logic [2:0]      fault
);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqReady && (memReq || done)));

  // R4
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[2:0] == 3'b000));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  // R5
  hard_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (fault == 3'd1 || fault == 3'd2)) |-> (prot == 3'b000 && physAddr == '0));

  // R8
  fault_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault <= 3'd5));

  // R8
  fo_partial_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault >= 3'd3) |-> (prot != 3'b111));

  // R9
  success_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 3'd0) |-> (prot != 3'b000));

endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqReady (reqReady),
  .memReq   (memReq),
  .memValid (memValid),
  .memAddr  (memAddr),
  .done     (done),
  .physAddr (physAddr),
  .prot     (prot),
  .fault    (fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVa = '0;
  logic [1:0]  reqAccess = '0;
  logic [1:0]  reqPriv = '0;
  logic        reqPhys = 1'b0;
  logic [63:0] ptBase = 64'h10000;
  logic        memReq;
  logic [63:0] memAddr;
  logic        memValid = 1'b0;
  logic [63:0] memData = '0;
  logic        done;
  logic [63:0] physAddr;
  logic [2:0]  prot;
  logic [2:0]  fault;

  int checks = 0;
  int failures = 0;
  int memLat = 0;
  int readCnt = 0;
  logic [63:0] readLog [64];

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqAccess(reqAccess), .reqPriv(reqPriv), .reqPhys(reqPhys),
    .ptBase(ptBase), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .done(done), .physAddr(physAddr), .prot(prot), .fault(fault)
  );

  // entry layout: valid bit 0, fault-on bits 1..3, read enables 8+p, write enables 12+p
  function automatic logic [63:0] memLookup(input logic [63:0] a);
    case (a)
      64'h10008: return 64'h0000_0020_0000_0101;
      64'h10010: return 64'h0000_0021_0000_0001;
      64'h40010: return 64'h0000_0030_0000_0101;
      64'h40028: return 64'h0000_0031_0000_0001;
      64'h60018: return 64'h0000_0055_0000_1901;
      64'h60020: return 64'h0000_0066_0000_1105;
      64'h60028: return 64'h0000_0077_0000_0109;
      64'h60030: return 64'h0000_0000_0000_0100;
      64'h60038: return 64'h0000_0088_0000_0103;
      default:   return 64'h0;
    endcase
  endfunction

  // memory responder
  initial begin
    int latCnt;
    latCnt = 0;
    forever begin
      @(negedge clk);
      if (memValid) begin
        memValid = 1'b0;
      end else if (memReq && rst_n) begin
        if (latCnt >= memLat) begin
          memData = memLookup(memAddr);
          readLog[readCnt % 64] = memAddr;
          readCnt = readCnt + 1;
          memValid = 1'b1;
          latCnt = 0;
        end else begin
          latCnt = latCnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runReq(input logic [63:0] va, input logic [1:0] acc,
                        input logic [1:0] priv, input logic ph,
                        output logic [63:0] gPhys, output logic [2:0] gProt,
                        output logic [2:0] gFault, output int gReads,
                        output int gWait, output bit gPulseOk);
    int startReads;
    int cyc;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    startReads = readCnt;
    reqVa = va; reqAccess = acc; reqPriv = priv; reqPhys = ph; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    gPhys = physAddr; gProt = prot; gFault = fault;
    gWait = cyc;
    @(negedge clk);
    gPulseOk = !done;
    gReads = readCnt - startReads;
  endtask

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  acc;
    logic [1:0]  priv;
    logic        ph;
    logic [63:0] ePhys;
    logic [2:0]  eProt;
    logic [2:0]  eFault;
    logic [3:0]  eReads;
    logic [7:0]  reqNo;
  } vecT;

  localparam int NVEC = 21;
  localparam vecT VECS [NVEC] = '{
    '{64'h0000_0002_0100_6123, 2'd0, 2'd0, 1'b0, 64'hAA123,  3'b111, 3'd0, 4'd3, 8'd9}, // R9 kernel read
    '{64'h0000_0002_0100_6123, 2'd1, 2'd0, 1'b0, 64'hAA123,  3'b111, 3'd0, 4'd3, 8'd7}, // R7 kernel write
    '{64'h0000_0002_0100_6123, 2'd2, 2'd3, 1'b0, 64'hAA123,  3'b101, 3'd0, 4'd3, 8'd7}, // R7 user fetch
    '{64'h0000_0002_0100_6123, 2'd1, 2'd3, 1'b0, 64'h0,      3'b000, 3'd1, 4'd3, 8'd7}, // R7 user write denied
    '{64'h0000_0002_0100_6123, 2'd0, 2'd1, 1'b0, 64'h0,      3'b000, 3'd1, 4'd3, 8'd7}, // R7 priv 1 read denied
    '{64'h0000_0002_0100_8010, 2'd1, 2'd0, 1'b0, 64'hCC010,  3'b101, 3'd4, 4'd3, 8'd8}, // R8 fault on write
    '{64'h0000_0002_0100_8010, 2'd0, 2'd0, 1'b0, 64'hCC010,  3'b101, 3'd0, 4'd3, 8'd8}, // R8 read survives
    '{64'h0000_0002_0100_A000, 2'd2, 2'd0, 1'b0, 64'hEE000,  3'b001, 3'd5, 4'd3, 8'd8}, // R8 fault on exec
    '{64'h0000_0002_0100_A000, 2'd3, 2'd0, 1'b0, 64'hEE000,  3'b001, 3'd0, 4'd3, 8'd7}, // R7 code 3 acts as read
    '{64'h0000_0002_0100_FFFF, 2'd0, 2'd0, 1'b0, 64'h111FFF, 3'b100, 3'd3, 4'd3, 8'd8}, // R8 fault on read
    '{64'h0000_0002_0100_C000, 2'd0, 2'd0, 1'b0, 64'h0,      3'b000, 3'd2, 4'd3, 8'd5}, // R5 leaf invalid
    '{64'h0000_0004_0000_0000, 2'd0, 2'd0, 1'b0, 64'h0,      3'b000, 3'd1, 4'd1, 8'd6}, // R6 level 1 no kre
    '{64'h0000_0006_0000_0000, 2'd0, 2'd0, 1'b0, 64'h0,      3'b000, 3'd2, 4'd1, 8'd5}, // R5 level 1 invalid
    '{64'h0000_0002_0280_0000, 2'd0, 2'd0, 1'b0, 64'h0,      3'b000, 3'd1, 4'd2, 8'd6}, // R6 level 2 no kre
    '{64'hDEAD_BEEF_1234_5678, 2'd1, 2'd3, 1'b1, 64'hDEAD_BEEF_1234_5678, 3'b111, 3'd0, 4'd0, 8'd1}, // R1
    '{64'h0000_8000_0000_0000, 2'd0, 2'd0, 1'b0, 64'h0,      3'b000, 3'd1, 4'd0, 8'd2}, // R2 bad extension
    '{64'hFFFF_FD12_3456_789A, 2'd0, 2'd0, 1'b0, 64'h0000_0812_3456_789A, 3'b111, 3'd0, 4'd0, 8'd3}, // R3 bit 40 set
    '{64'hFFFF_FD12_3456_789A, 2'd0, 2'd3, 1'b0, 64'h0,      3'b000, 3'd1, 4'd0, 8'd3}, // R3 user denied
    '{64'hFFFF_FE00_0000_0000, 2'd0, 2'd0, 1'b0, 64'h0,      3'b000, 3'd2, 4'd1, 8'd5}, // R5 negative, outside window
    '{64'h0000_0400_0000_0000, 2'd0, 2'd0, 1'b0, 64'h0,      3'b000, 3'd2, 4'd1, 8'd2}, // R2 bit 42 alone walks
    '{64'hFFFF_FC00_0000_1000, 2'd2, 2'd0, 1'b0, 64'h1000,   3'b111, 3'd0, 4'd0, 8'd3}  // R3 bit 40 clear
  };

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] gPhys;
    logic [2:0]  gProt, gFault;
    int gReads, gWait, base;
    bit gPulse;
    string tag;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(reqReady == 1'b1, "R11", "reqReady", 64'(reqReady), 64'd1);
    chk(done == 1'b0 && memReq == 1'b0, "R11", "done/memReq", {62'd0, done, memReq}, 64'd0);
    chk(physAddr == '0 && prot == '0 && fault == '0, "R11", "results",
        physAddr | 64'(prot) | 64'(fault), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      memLat = i % 3;
      runReq(VECS[i].va, VECS[i].acc, VECS[i].priv, VECS[i].ph,
             gPhys, gProt, gFault, gReads, gWait, gPulse);
      tag = $sformatf("R%0d", VECS[i].reqNo);
      chk(gFault == VECS[i].eFault, tag, $sformatf("vec %0d fault", i), 64'(gFault), 64'(VECS[i].eFault));
      chk(gProt == VECS[i].eProt, tag, $sformatf("vec %0d prot", i), 64'(gProt), 64'(VECS[i].eProt));
      chk(gPhys == VECS[i].ePhys, tag, $sformatf("vec %0d phys", i), gPhys, VECS[i].ePhys);
      chk(gReads == int'(VECS[i].eReads), tag, $sformatf("vec %0d reads", i), 64'(gReads), 64'(VECS[i].eReads));
      // R10 single pulse
      chk(gPulse, "R10", $sformatf("vec %0d done width", i), 64'(!gPulse), 64'd0);
    end

    // R1 bypass completes on the first cycle after acceptance
    runReq(64'h1234, 2'd0, 2'd0, 1'b1, gPhys, gProt, gFault, gReads, gWait, gPulse);
    chk(gWait == 0, "R1", "bypass latency", 64'(gWait), 64'd0);

    // R4 read addresses of a full walk
    memLat = 1;
    base = readCnt;
    runReq(64'h0000_0002_0100_6123, 2'd0, 2'd0, 1'b0, gPhys, gProt, gFault, gReads, gWait, gPulse);
    chk(readLog[base % 64] == 64'h10008, "R4", "level 1 address", readLog[base % 64], 64'h10008);
    chk(readLog[(base+1) % 64] == 64'h40010, "R4", "level 2 address", readLog[(base+1) % 64], 64'h40010);
    chk(readLog[(base+2) % 64] == 64'h60018, "R4", "level 3 address", readLog[(base+2) % 64], 64'h60018);

    // R10 request offered while busy is ignored
    memLat = 2;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    base = readCnt;
    reqVa = 64'h0000_0002_0100_6123; reqAccess = 2'd0; reqPriv = 2'd0; reqPhys = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    reqVa = 64'h0000_0000_0000_4321; reqPhys = 1'b1;
    gWait = 0;
    while (!done && gWait < 200) begin
      @(negedge clk);
      gWait++;
    end
    reqValid = 1'b0;
    chk(physAddr == 64'hAA123, "R10", "busy result kept", physAddr, 64'hAA123);
    chk((readCnt - base) == 3, "R10", "busy reads", 64'(readCnt - base), 64'd3);
    @(negedge clk);
    chk(done == 1'b0 && reqReady == 1'b1, "R10", "no second completion",
        {62'd0, done, reqReady}, 64'd1);
    @(negedge clk);
    chk(done == 1'b0 && memReq == 1'b0, "R10", "busy request dropped",
        {62'd0, done, memReq}, 64'd0);
    reqPhys = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule